// File: doc/BRIEF.md
# Table-Paced Trigger Burst Generator

This block emits a burst of single-cycle trigger pulses whose spacing is set entry by entry from an interval table. The host fills the table (1024 words of 32 bits) through a simple write port, programs a burst length and raises `start`. An address pointer walks the table and a down counter, reloaded from the current entry at each pulse, times the gap to the next pulse. Any interval smaller than three cycles is raised to three, so that a downstream serial command encoder, which needs three cycles per command, is never overrun.

For every pulse the block records two numbers in two separate 256-entry FIFOs. One is an event number that counts pulses since reset. The other is a free-running bunch counter that an external bunch-zero strobe clears. The host reads both FIFOs later and compares them with the numbers that the front-end chips put in their packet headers. A burst ends once the programmed number of pulses has been produced, or when `abort` arrives. A done flag then stays high until the next start.

Top module: `trig_burst_gen`

## Requirements
- R1: After reset `pulse` and `done` are low, both FIFOs are empty (`evtEmpty`/`bxEmpty` high) and both overflow flags are low.
- R2: When `start` is sampled at clock edge S, the first pulse rises at edge S + T0 + 2, where T0 is table entry 0 after the floor of R4 is applied.
- R3: Each pulse is high for exactly one cycle. The pulse after pulse k (counting from 0) rises exactly Tk+1 cycles later, where Tk+1 is table entry k+1 after the floor of R4.
- R4: A table entry with a value of 0, 1 or 2 is treated as 3.
- R5: A burst holds `burstLen` pulses. Values above 1024 are treated as 1024. `done` goes high in the same cycle as the final pulse and stays high with no further pulses until the next `start`, which drops it. With `burstLen` = 0, `done` is high in the cycle after the start edge and no pulse is produced.
- R6: If `abort` is sampled during a burst, no pulse rises at or after that edge, and `done` is high in the following cycle. `abort` takes precedence over a simultaneous `start`.
- R7: Each pulse pushes into the event FIFO the number of pulses produced since reset, modulo 2^16, starting at 0.
- R8: The bunch counter (12 bits) advances every cycle and is cleared by `bunchZero`. If `bunchZero` is sampled at edge B and a pulse rises at edge P, the bunch FIFO receives (P − B − 1) mod 4096.
- R9: Each FIFO holds 256 entries and shows its oldest entry on its read data port while its empty flag is low. A high read enable pops one entry per cycle. A read of an empty FIFO is ignored.
- R10: A push into a full FIFO is dropped and the FIFO keeps its first 256 entries. The overflow flag of that FIFO is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst from table entry 0 |
| abort | input | 1 | Stop the running burst |
| burstLen | input | 11 | Number of pulses in the burst (values above 1024 are treated as 1024) |
| bunchZero | input | 1 | Clears the bunch counter |
| memWrEn | input | 1 | Interval table write enable |
| memWrAddr | input | 10 | Interval table write address |
| memWrData | input | 32 | Interval value in cycles |
| pulse | output | 1 | One-cycle trigger pulse |
| done | output | 1 | Burst finished or aborted |
| evtRdEn | input | 1 | Pop the event FIFO |
| evtRdData | output | 16 | Oldest event number |
| evtEmpty | output | 1 | Event FIFO empty |
| evtOverflow | output | 1 | Sticky: an event push was dropped |
| bxRdEn | input | 1 | Pop the bunch FIFO |
| bxRdData | output | 12 | Oldest bunch number |
| bxEmpty | output | 1 | Bunch FIFO empty |
| bxOverflow | output | 1 | Sticky: a bunch push was dropped |

## Verification
The bench uses distinct intervals and compares each measured gap with the table entry that should have set it. A pointer that advances one step late, or a counter that is off by one on reload, shows up as a first latency or gap that is one cycle wrong. Entries of 0, 1 and 2 must all come out as three-cycle gaps; a design without the floor would fire pulses back to back or stall. A zero length, an oversized length that must be limited to 1024, and an abort in the middle of a long gap are each checked: a wrong design would emit an extra pulse, run past the table or never raise done. The long burst fills both FIFOs past capacity, so a design that overwrote old entries or cleared the sticky flag on a read would return wrong numbers or a low overflow flag.

// File: rtl/trig_burst_pkg.sv
package trig_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_LOAD,
    ST_RUN,
    ST_DONE
  } burstState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;   // down counter may decrement
    logic load;  // load first interval
    logic fire;  // emit a pulse, log numbers, reload next interval
  } burstStrobe_t;

endpackage

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int WIDTH = 16,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             overflow
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [AW:0]      fill;
  logic             full;
  logic             doPush;
  logic             doPop;

  assign full   = (fill == (AW+1)'(DEPTH));
  assign empty  = (fill == '0);
  assign doPush = pushEn && !full;
  assign doPop  = popEn && !empty;
  assign popData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (pushEn && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_burst_dp.sv
module trig_burst_dp
  import trig_burst_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int INTERVAL_W = 32,
  parameter int MIN_GAP    = 3,
  parameter int EVT_W      = 16,
  parameter int BX_W       = 12,
  parameter int FIFO_AW    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  memWrEn,
  input  logic [ADDR_W-1:0]     memWrAddr,
  input  logic [INTERVAL_W-1:0] memWrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  burstStrobe_t          strobe,
  input  logic                  bunchZero,
  output logic                  expire,
  output logic                  pulse,
  input  logic                  evtRdEn,
  output logic [EVT_W-1:0]      evtRdData,
  output logic                  evtEmpty,
  output logic                  evtOverflow,
  input  logic                  bxRdEn,
  output logic [BX_W-1:0]       bxRdData,
  output logic                  bxEmpty,
  output logic                  bxOverflow
);
  localparam int TABLE_DEPTH = 1 << ADDR_W;
  localparam logic [INTERVAL_W-1:0] GAP_FLOOR = INTERVAL_W'(MIN_GAP);

  logic [INTERVAL_W-1:0] intervalMem [TABLE_DEPTH];
  logic [INTERVAL_W-1:0] rdWord;
  logic [INTERVAL_W-1:0] nextGap;
  logic [INTERVAL_W-1:0] gapCnt;
  logic [EVT_W-1:0]      evtCnt;
  logic [BX_W-1:0]       bxCnt;

  // Interval table: host write port, registered read toward the pacer
  always_ff @(posedge clk) begin
    if (memWrEn) intervalMem[memWrAddr] <= memWrData;
    rdWord <= intervalMem[rdAddr];
  end

  // Floor keeps pulses far enough apart for a 3-cycle serial encoder
  assign nextGap = (rdWord < GAP_FLOOR) ? GAP_FLOOR : rdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.load || strobe.fire) begin
      gapCnt <= nextGap;
    end else if (strobe.run && (gapCnt != '0)) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign expire = (gapCnt == INTERVAL_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulse  <= 1'b0;
      evtCnt <= '0;
      bxCnt  <= '0;
    end else begin
      pulse <= strobe.fire;
      if (strobe.fire) evtCnt <= evtCnt + 1'b1;
      bxCnt <= bunchZero ? '0 : bxCnt + 1'b1;
    end
  end

  trig_fifo #(.WIDTH(EVT_W), .AW(FIFO_AW)) u_evtFifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (strobe.fire),
    .pushData (evtCnt),
    .popEn    (evtRdEn),
    .popData  (evtRdData),
    .empty    (evtEmpty),
    .overflow (evtOverflow)
  );

  trig_fifo #(.WIDTH(BX_W), .AW(FIFO_AW)) u_bxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (strobe.fire),
    .pushData (bxCnt),
    .popEn    (bxRdEn),
    .popData  (bxRdData),
    .empty    (bxEmpty),
    .overflow (bxOverflow)
  );
endmodule

// File: rtl/trig_burst_ctrl.sv
module trig_burst_ctrl
  import trig_burst_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W:0]   burstLen,
  input  logic              expire,
  output logic [ADDR_W-1:0] rdAddr,
  output burstStrobe_t      strobe,
  output logic              done
);
  localparam int LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1 << ADDR_W);

  burstState_t       state;
  logic [ADDR_W-1:0] ptr;
  logic [LEN_W-1:0]  left;
  logic [LEN_W-1:0]  lenEff;
  logic              active;
  logic              goAbort;
  logic              hold;

  assign lenEff  = (burstLen > MAX_LEN) ? MAX_LEN : burstLen;
  assign active  = (state == ST_PRIME) || (state == ST_LOAD) || (state == ST_RUN);
  assign goAbort = abort && active;
  assign hold    = goAbort || start;

  always_comb begin
    strobe.load = (state == ST_LOAD) && !hold;
    strobe.run  = (state == ST_RUN) && !hold;
    strobe.fire = (state == ST_RUN) && expire && !hold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ptr   <= '0;
      left  <= '0;
    end else if (goAbort) begin
      state <= ST_DONE;
    end else if (start) begin
      ptr   <= '0;
      left  <= lenEff;
      state <= (lenEff == '0) ? ST_DONE : ST_PRIME;
    end else begin
      case (state)
        ST_PRIME: state <= ST_LOAD;
        ST_LOAD: begin
          ptr   <= ptr + 1'b1;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (expire) begin
            ptr  <= ptr + 1'b1;
            left <= left - 1'b1;
            if (left == LEN_W'(1)) state <= ST_DONE;
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign rdAddr = ptr;
  assign done   = (state == ST_DONE);
endmodule

// File: rtl/trig_burst_gen.sv
module trig_burst_gen
  import trig_burst_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int INTERVAL_W = 32,
  parameter int MIN_GAP    = 3,
  parameter int EVT_W      = 16,
  parameter int BX_W       = 12,
  parameter int FIFO_AW    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  abort,
  input  logic [ADDR_W:0]       burstLen,
  input  logic                  bunchZero,
  input  logic                  memWrEn,
  input  logic [ADDR_W-1:0]     memWrAddr,
  input  logic [INTERVAL_W-1:0] memWrData,
  output logic                  pulse,
  output logic                  done,
  input  logic                  evtRdEn,
  output logic [EVT_W-1:0]      evtRdData,
  output logic                  evtEmpty,
  output logic                  evtOverflow,
  input  logic                  bxRdEn,
  output logic [BX_W-1:0]       bxRdData,
  output logic                  bxEmpty,
  output logic                  bxOverflow
);
  burstStrobe_t      strobe;
  logic              expire;
  logic [ADDR_W-1:0] rdAddr;

  trig_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .abort    (abort),
    .burstLen (burstLen),
    .expire   (expire),
    .rdAddr   (rdAddr),
    .strobe   (strobe),
    .done     (done)
  );

  trig_burst_dp #(
    .ADDR_W     (ADDR_W),
    .INTERVAL_W (INTERVAL_W),
    .MIN_GAP    (MIN_GAP),
    .EVT_W      (EVT_W),
    .BX_W       (BX_W),
    .FIFO_AW    (FIFO_AW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .rdAddr      (rdAddr),
    .strobe      (strobe),
    .bunchZero   (bunchZero),
    .expire      (expire),
    .pulse       (pulse),
    .evtRdEn     (evtRdEn),
    .evtRdData   (evtRdData),
    .evtEmpty    (evtEmpty),
    .evtOverflow (evtOverflow),
    .bxRdEn      (bxRdEn),
    .bxRdData    (bxRdData),
    .bxEmpty     (bxEmpty),
    .bxOverflow  (bxOverflow)
  );
endmodule

// File: rtl/trig_burst_sva.sv
module trig_burst_sva (
  input logic clk,
  input logic rstN,
  input logic pulse,
  input logic done,
  input logic evtEmpty,
  input logic bxEmpty,
  input logic evtOverflow,
  input logic bxOverflow
);
  // R3: a pulse lasts one cycle
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);

  // R4: floored gap leaves at least two idle cycles after a pulse
  p_pulse_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulse) |=> !pulse);

  // R5: no pulse while the burst stays finished
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> !pulse);

  // R7: every pulse leaves an entry in both FIFOs
  p_push_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    pulse |-> (!evtEmpty && !bxEmpty));

  // R10: overflow flags are sticky
  p_evt_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    evtOverflow |=> evtOverflow);

  p_bx_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    bxOverflow |=> bxOverflow);
endmodule

bind trig_burst_gen trig_burst_sva u_sva (
  .clk         (clk),
  .rstN        (rstN),
  .pulse       (pulse),
  .done        (done),
  .evtEmpty    (evtEmpty),
  .bxEmpty     (bxEmpty),
  .evtOverflow (evtOverflow),
  .bxOverflow  (bxOverflow)
);

// File: tb/trig_burst_gen_bench.sv
`timescale 1ns/1ps
module trig_burst_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [10:0] burstLen = '0;
  logic        bunchZero = 1'b0;
  logic        memWrEn = 1'b0;
  logic [9:0]  memWrAddr = '0;
  logic [31:0] memWrData = '0;
  logic        pulse;
  logic        done;
  logic        evtRdEn = 1'b0;
  logic [15:0] evtRdData;
  logic        evtEmpty;
  logic        evtOverflow;
  logic        bxRdEn = 1'b0;
  logic [11:0] bxRdData;
  logic        bxEmpty;
  logic        bxOverflow;

  always #4 clk = ~clk;

  trig_burst_gen u_trig_burst_gen (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .burstLen(burstLen),
    .bunchZero(bunchZero), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .pulse(pulse), .done(done),
    .evtRdEn(evtRdEn), .evtRdData(evtRdData), .evtEmpty(evtEmpty),
    .evtOverflow(evtOverflow), .bxRdEn(bxRdEn), .bxRdData(bxRdData),
    .bxEmpty(bxEmpty), .bxOverflow(bxOverflow)
  );

  int checks = 0;
  int fails = 0;
  int cycleCount = 0;
  int startCyc = 0;
  int totalPulses = 0;
  logic [11:0] modelBx = '0;
  int pulseCyc[$];
  bit pulseDone[$];
  logic [15:0] expEvt[$];
  logic [11:0] expBx[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cycleCount <= cycleCount + 1;

  // Bunch counter model from R8
  always @(posedge clk) begin
    if (!rstN || bunchZero) modelBx <= '0;
    else modelBx <= modelBx + 12'd1;
  end

  // Pulse monitor; FIFO model per R7, R8, R10
  always @(negedge clk) begin
    if (rstN === 1'b1 && pulse === 1'b1) begin
      pulseCyc.push_back(cycleCount);
      pulseDone.push_back(done);
      if (expEvt.size() < 256) begin
        expEvt.push_back(16'(totalPulses));
        expBx.push_back(modelBx - 12'd1);
      end
      totalPulses++;
    end
  end

  task automatic writeEntry(input int addr, input int val);
    @(negedge clk);
    memWrEn = 1'b1;
    memWrAddr = 10'(addr);
    memWrData = 32'(val);
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic launch(input int len);
    pulseCyc.delete();
    pulseDone.delete();
    @(negedge clk);
    start = 1'b1;
    burstLen = 11'(len);
    @(posedge clk);
    #1 startCyc = cycleCount;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic drain(input string req, output int count);
    count = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #1;
      if (evtEmpty) break;
      chk(evtRdData == expEvt[0], req, "event number", evtRdData, expEvt[0]);
      chk(bxRdData == expBx[0], "R8", "bunch number", bxRdData, expBx[0]);
      void'(expEvt.pop_front());
      void'(expBx.pop_front());
      evtRdEn = 1'b1;
      bxRdEn = 1'b1;
      count++;
      @(negedge clk);
      evtRdEn = 1'b0;
      bxRdEn = 1'b0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(pulse == 1'b0, "R1", "pulse after reset", pulse, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(evtEmpty && bxEmpty, "R1", "fifos empty after reset", {evtEmpty, bxEmpty}, 3);
    chk(!evtOverflow && !bxOverflow, "R1", "overflow after reset", {evtOverflow, bxOverflow}, 0);
  endtask

  task automatic t_basic;
    int n;
    @(negedge clk);
    bunchZero = 1'b1;
    @(negedge clk);
    bunchZero = 1'b0;
    writeEntry(0, 5);
    writeEntry(1, 7);
    writeEntry(2, 4);
    writeEntry(3, 10);
    launch(4);
    waitDone(200);
    repeat (30) @(negedge clk);
    chk(pulseCyc.size() == 4, "R5", "pulse count basic", pulseCyc.size(), 4);
    if (pulseCyc.size() == 4) begin
      chk(pulseCyc[0] - startCyc == 7, "R2", "first latency", pulseCyc[0] - startCyc, 7);
      chk(pulseCyc[1] - pulseCyc[0] == 7, "R3", "gap 1", pulseCyc[1] - pulseCyc[0], 7);
      chk(pulseCyc[2] - pulseCyc[1] == 4, "R3", "gap 2", pulseCyc[2] - pulseCyc[1], 4);
      chk(pulseCyc[3] - pulseCyc[2] == 10, "R3", "gap 3", pulseCyc[3] - pulseCyc[2], 10);
      chk(pulseDone[2] == 1'b0, "R5", "done before last pulse", pulseDone[2], 0);
      chk(pulseDone[3] == 1'b1, "R5", "done with last pulse", pulseDone[3], 1);
    end
    chk(done == 1'b1, "R5", "done held", done, 1);
    drain("R7", n);
    chk(n == 4, "R9", "entries read basic", n, 4);
  endtask

  task automatic t_clamp;
    int n;
    writeEntry(0, 0);
    writeEntry(1, 1);
    writeEntry(2, 2);
    writeEntry(3, 3);
    launch(4);
    chk(done == 1'b0, "R5", "start drops done", done, 0);
    waitDone(200);
    repeat (10) @(negedge clk);
    chk(pulseCyc.size() == 4, "R4", "pulse count clamp", pulseCyc.size(), 4);
    if (pulseCyc.size() == 4) begin
      chk(pulseCyc[0] - startCyc == 5, "R4", "first latency floor", pulseCyc[0] - startCyc, 5);
      for (int k = 1; k < 4; k++)
        chk(pulseCyc[k] - pulseCyc[k-1] == 3, "R4", "floored gap", pulseCyc[k] - pulseCyc[k-1], 3);
    end
    drain("R7", n);
  endtask

  task automatic t_zero_len;
    launch(0);
    chk(done == 1'b1, "R5", "done after zero length", done, 1);
    repeat (12) @(negedge clk);
    chk(pulseCyc.size() == 0, "R5", "pulses for zero length", pulseCyc.size(), 0);
  endtask

  task automatic t_abort;
    int n;
    for (int a = 0; a < 10; a++) writeEntry(a, 20);
    launch(10);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1;
      if (pulseCyc.size() >= 2) break;
    end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(done == 1'b1, "R6", "done after abort", done, 1);
    repeat (60) @(negedge clk);
    chk(pulseCyc.size() == 2, "R6", "pulses after abort", pulseCyc.size(), 2);
    // abort and start together: abort wins only if active; here idle-done so start runs
    launch(1);
    chk(done == 1'b0, "R5", "restart drops done", done, 0);
    waitDone(200);
    repeat (4) @(negedge clk);
    chk(pulseCyc.size() == 1, "R5", "pulses single burst", pulseCyc.size(), 1);
    if (pulseCyc.size() == 1)
      chk(pulseCyc[0] - startCyc == 22, "R2", "latency 20", pulseCyc[0] - startCyc, 22);
    drain("R7", n);
    chk(n == 3, "R9", "entries after abort", n, 3);
  endtask

  task automatic t_abort_beats_start;
    launch(10);
    repeat (3) @(negedge clk);
    abort = 1'b1;
    start = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    start = 1'b0;
    chk(done == 1'b1, "R6", "abort wins over start", done, 1);
    repeat (30) @(negedge clk);
    chk(pulseCyc.size() == 0, "R6", "no pulse after abort+start", pulseCyc.size(), 0);
  endtask

  task automatic t_overflow;
    int n;
    int bad;
    for (int a = 0; a < 1024; a++) writeEntry(a, 3);
    launch(2047);
    waitDone(5000);
    repeat (6) @(negedge clk);
    chk(pulseCyc.size() == 1024, "R5", "length limited to 1024", pulseCyc.size(), 1024);
    bad = 0;
    for (int k = 1; k < pulseCyc.size(); k++)
      if (pulseCyc[k] - pulseCyc[k-1] != 3) bad++;
    chk(bad == 0, "R3", "gaps in long burst", bad, 0);
    chk(evtOverflow == 1'b1, "R10", "event overflow", evtOverflow, 1);
    chk(bxOverflow == 1'b1, "R10", "bunch overflow", bxOverflow, 1);
    drain("R10", n);
    chk(n == 256, "R9", "fifo depth", n, 256);
    chk(evtOverflow && bxOverflow, "R10", "overflow sticky after read", {evtOverflow, bxOverflow}, 3);
    chk(evtEmpty && bxEmpty, "R9", "empty after drain", {evtEmpty, bxEmpty}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_clamp();
    t_zero_len();
    t_abort();
    t_abort_beats_start();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule